// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block drives a square-wave buzzer pin from a slow timebase enable that pulses at 75 kHz. A single-cycle command loads a tone selection and a cadence pattern, and it either starts or stops the tone. Every tone and cadence interval is a whole number of timebase ticks. The cadence can be a steady tone, one timed burst, a 10 Hz on/off chop, or a 10 Hz chop that sounds only in the first half of every second.

The tone divider alternates between a high half and a low half of fixed tick counts. For the two settings whose ideal half period is not a whole number of ticks, the high half is one tick longer than the low half, so the full period is exact. The busy flag shows that a pattern is active. It drops on a stop command, and in burst mode it also drops by itself when the burst ends.

Top module: `buzz_tone_gen`

## Requirements
- R1: After a synchronous reset, `buzz_o` and `busy_o` are both low.
- R2: A command with `cmd_run_i`=1 loads tone and mode and restarts all counters. From the next cycle `busy_o` and `buzz_o` are high, and tick number n counts from 0 at that point.
- R3: A command with `cmd_run_i`=0 drops `busy_o` and `buzz_o` on the next cycle, whatever the mode.
- R4: Tone code 0 is high 50 ticks then low 50 (750 Hz). Code 1 is high 38 then low 37 (1 kHz). Code 2 is high 25 then low 25 (1.5 kHz). Code 3 is high 13 then low 12 (3 kHz). The pattern repeats from the start.
- R5: The tone and cadence counters advance only in cycles where `tick_i` is high and no command is present. Gaps in the tick stream stretch the waveform but do not change it.
- R6: Mode 0 (continuous) sounds the tone without gating until a stop command arrives.
- R7: Mode 1 (single-shot) sounds for 2·CHOP_TICKS ticks (100 ms by default). Then `busy_o` and `buzz_o` go low and stay low.
- R8: Mode 2 gates the tone on for CHOP_TICKS ticks and off for CHOP_TICKS ticks, repeating. CHOP_TICKS defaults to 3750, which is 50 ms.
- R9: Mode 3 repeats every 20·CHOP_TICKS ticks (1 s). The first 10·CHOP_TICKS ticks of each period follow the mode 2 chop, and the remaining ticks are silent.
- R10: While idle, `buzz_o` stays low whatever `tick_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 75 kHz timebase enable, one cycle wide |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_run_i | input | 1 | 1 = start with the given settings, 0 = stop |
| cmd_tone_i | input | 2 | Tone code (R4) |
| cmd_mode_i | input | 2 | Cadence mode (R6 to R9) |
| buzz_o | output | 1 | Buzzer square wave |
| busy_o | output | 1 | Pattern active |

## Verification
The properties assume that a command is a single-cycle strobe. They also assume that `busy_o` can only be high after a start command has been seen since reset, because the checker tracks the active mode from the command port alone. The stimulus always pulses `cmd_valid_i` for exactly one cycle with `tick_i` low in that cycle. It drives the tick stream either continuously or with one missing tick in every three, and it compares every cycle against arithmetic on the count of ticks delivered since the command.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        MODE_CONT = 2'd0,
        MODE_ONCE = 2'd1,
        MODE_CHOP = 2'd2,
        MODE_SLOW = 2'd3
    } cad_mode_e;

    localparam int HALF_W          = 6;
    localparam int SLOTS_PER_CYCLE = 10;
    localparam int SLOTS_ON        = 5;

    typedef struct packed {
        logic [1:0] tone;
        cad_mode_e  mode;
    } buzz_cfg_t;

    // Tick count of one tone half; high half is the longer one when odd.
    function automatic logic [HALF_W-1:0] half_ticks(input logic [1:0] sel,
                                                     input logic       hi);
        logic [HALF_W-1:0] r;
        case (sel)
            2'd0:    r = HALF_W'(50);
            2'd1:    r = hi ? HALF_W'(38) : HALF_W'(37);
            2'd2:    r = HALF_W'(25);
            default: r = hi ? HALF_W'(13) : HALF_W'(12);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/buzz_tone_div.sv
module buzz_tone_div
    import buzz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       adv,
    input  logic [1:0] sel,
    output logic       lvl_o
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] limit;
    logic              lvl_q;

    always_comb limit = half_ticks(sel, lvl_q) - HALF_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (adv) begin
            if (cnt_q == limit) begin
                cnt_q <= '0;
                lvl_q <= ~lvl_q;
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/buzz_cadence.sv
module buzz_cadence
    import buzz_pkg::*;
#(
    parameter int CHOP_TICKS = 3750
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      adv,
    input  cad_mode_e mode,
    output logic      gate_o,
    output logic      done_o
);

    localparam int CYC = 2 * CHOP_TICKS;
    localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1;
    localparam int SW  = $clog2(SLOTS_PER_CYCLE);

    logic [CW-1:0] chop_q;
    logic [SW-1:0] slot_q;
    logic          chop_wrap;
    logic          chop_on;
    logic          slot_on;

    assign chop_wrap = adv && (chop_q == CW'(CYC - 1));
    assign chop_on   = chop_q < CW'(CHOP_TICKS);
    assign slot_on   = slot_q < SW'(SLOTS_ON);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            chop_q <= '0;
            slot_q <= '0;
        end else if (adv) begin
            if (chop_wrap) begin
                chop_q <= '0;
                slot_q <= (slot_q == SW'(SLOTS_PER_CYCLE - 1)) ? '0 : slot_q + SW'(1);
            end else begin
                chop_q <= chop_q + CW'(1);
            end
        end
    end

    always_comb begin
        case (mode)
            MODE_CHOP: gate_o = chop_on;
            MODE_SLOW: gate_o = chop_on && slot_on;
            default:   gate_o = 1'b1;
        endcase
    end

    assign done_o = chop_wrap && (mode == MODE_ONCE);

endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
    import buzz_pkg::*;
#(
    parameter int CHOP_TICKS = 3750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       cmd_valid_i,
    input  logic       cmd_run_i,
    input  logic [1:0] cmd_tone_i,
    input  logic [1:0] cmd_mode_i,
    output logic       buzz_o,
    output logic       busy_o
);

    buzz_cfg_t cfg_q;
    logic      run_q;
    logic      adv;
    logic      lvl;
    logic      gate;
    logic      done;

    assign adv = run_q && tick_i && !cmd_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{tone: 2'd0, mode: MODE_CONT};
            run_q <= 1'b0;
        end else if (cmd_valid_i) begin
            run_q <= cmd_run_i;
            if (cmd_run_i) begin
                cfg_q.tone <= cmd_tone_i;
                cfg_q.mode <= cad_mode_e'(cmd_mode_i);
            end
        end else if (done) begin
            run_q <= 1'b0;
        end
    end

    buzz_tone_div u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd_valid_i),
        .adv     (adv),
        .sel     (cfg_q.tone),
        .lvl_o   (lvl)
    );

    buzz_cadence #(.CHOP_TICKS(CHOP_TICKS)) u_cad (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd_valid_i),
        .adv     (adv),
        .mode    (cfg_q.mode),
        .gate_o  (gate),
        .done_o  (done)
    );

    assign buzz_o = run_q && gate && lvl;
    assign busy_o = run_q;

endmodule

// File: rtl/buzz_tone_gen_chk.sv
module buzz_tone_gen_chk
    import buzz_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       cmd_valid_i,
    input logic       cmd_run_i,
    input logic [1:0] cmd_tone_i,
    input logic [1:0] cmd_mode_i,
    input logic       buzz_o,
    input logic       busy_o
);

    logic [1:0] seen_mode;

    always_ff @(posedge clk) begin
        if (rst)                           seen_mode <= 2'd0;
        else if (cmd_valid_i && cmd_run_i) seen_mode <= cmd_mode_i;
    end

    a_r2_start_sounds: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && cmd_run_i |=> busy_o && buzz_o);

    a_r3_stop_at_once: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && !cmd_run_i |=> !busy_o && !buzz_o);

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i && !cmd_valid_i |=> $stable(buzz_o) && $stable(busy_o));

    a_r10_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !buzz_o);

    a_r7_only_burst_ends: assert property (@(posedge clk) disable iff (rst)
        busy_o && !cmd_valid_i && seen_mode != 2'd1 |=> busy_o);

endmodule

bind buzz_tone_gen buzz_tone_gen_chk u_chk (.*);

// File: tb/tb_buzz_tone_gen.sv
module tb_buzz_tone_gen;

    localparam int C = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic       cmd_run_i = 1'b0;
    logic [1:0] cmd_tone_i = 2'd0;
    logic [1:0] cmd_mode_i = 2'd0;
    logic       buzz_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    buzz_tone_gen #(.CHOP_TICKS(C)) dut (.*);

    function automatic int hi_len(input int t);
        case (t)
            0: return 50;
            1: return 38;
            2: return 25;
            default: return 13;
        endcase
    endfunction

    function automatic int lo_len(input int t);
        case (t)
            0: return 50;
            1: return 37;
            2: return 25;
            default: return 12;
        endcase
    endfunction

    function automatic bit exp_busy(input int m, input int n);
        return (m == 1) ? (n < 2 * C) : 1'b1;
    endfunction

    function automatic bit exp_buzz(input int t, input int m, input int n);
        int  chop = n % (2 * C);
        int  slot = (n / (2 * C)) % 10;
        bit  lvl  = (n % (hi_len(t) + lo_len(t))) < hi_len(t);
        bit  gate;
        case (m)
            2: gate = chop < C;
            3: gate = (chop < C) && (slot < 5);
            default: gate = 1'b1;
        endcase
        return exp_busy(m, n) && gate && lvl;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input bit run, input int t, input int m);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_run_i   = run;
        cmd_tone_i  = 2'(t);
        cmd_mode_i  = 2'(m);
        tick_i      = 1'b0;
        @(posedge clk);
    endtask

    task automatic run_test(input int t, input int m, input int cycles,
                            input bit gap, input string tag);
        int n = 0;
        send(1'b1, t, m);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cmd_valid_i = 1'b0;
            check(busy_o, exp_busy(m, n), {tag, " busy"});
            check(buzz_o, exp_buzz(t, m, n), {tag, " buzz"});
            tick_i = gap ? ((i % 3) != 2) : 1'b1;
            @(posedge clk);
            if (tick_i) n++;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(buzz_o, 1'b0, "R1 reset buzz");
        check(busy_o, 1'b0, "R1 reset busy");

        // R10: ticks while idle leave the pin low
        for (int i = 0; i < 20; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            check(buzz_o, 1'b0, "R10 idle");
        end

        // R4 R6 R2: every tone, continuous
        for (int t = 0; t < 4; t++) run_test(t, 0, 260, 1'b0, "R2 R4 R6");
        // R5: gapped ticks
        run_test(1, 0, 300, 1'b1, "R5 R4");
        run_test(3, 2, 700, 1'b1, "R5 R8");
        // R7: single shot for every tone, run past the end
        for (int t = 0; t < 4; t++) run_test(t, 1, 2 * C + 40, 1'b0, "R7");
        // R8: chop
        run_test(0, 2, 5 * C, 1'b0, "R8");
        run_test(2, 2, 5 * C, 1'b0, "R8");
        // R9: slow cadence beyond one full period
        run_test(1, 3, 22 * C, 1'b0, "R9");
        run_test(3, 3, 22 * C, 1'b1, "R9 R5");

        // R3: stop mid-pattern, then idle ticks
        run_test(0, 0, 30, 1'b0, "R2");
        send(1'b0, 0, 0);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        check(busy_o, 1'b0, "R3 stop busy");
        check(buzz_o, 1'b0, "R3 stop buzz");
        for (int i = 0; i < 30; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            check(buzz_o, 1'b0, "R10 after stop");
            check(busy_o, 1'b0, "R3 stays idle");
        end
        // R2: restart begins from a fresh phase
        run_test(2, 3, 120, 1'b0, "R2 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule